// File: doc/BRIEF.md
# Address Range Match Scanner

This block decides whether a 32-bit IPv4 address belongs to any of a set of configured network ranges. An exact-match store has no don't-care bits, so each range is kept in two parts. A table of 16 subnet masks holds the "which bits are network" half. A second table of 16 network identifiers holds the masked addresses that are permitted. A filtering pipeline would use one copy of the block for source addresses and a second copy for destination addresses.

A scan starts from a one-cycle `start` pulse that carries the address. The scanner then reads one mask entry per clock, starting at entry 0 and moving upwards. In the same clock it ANDs the address with that mask and compares the result against every valid network identifier. The scan ends at the first hit, at the first mask entry that is not valid, or after the last entry. In every case the block reports pass or no-match together with the number of scan cycles used. Latency therefore grows with the number of populated mask entries. Software fills both tables through a single write port, and that port is locked while a scan is running.

Top module: `range_match_scanner`

## Requirements
- R1: After reset, `done`, `hit` and `cycles` are 0 and every entry of both tables is invalid.
- R2: A `start` pulse seen while idle captures `addrIn` and begins a scan. Each scan cycle examines exactly one mask entry, in ascending index order from entry 0.
- R3: A scan ends with `hit`=1 at the first valid mask entry i for which (address AND mask[i]) equals some valid network identifier. In that case `cycles`=i+1, and the boundary case is a hit on entry 15, which gives `cycles`=16.
- R4: If all 16 mask entries are valid and none of them produces a match, the scan ends with `hit`=0 and `cycles`=16.
- R5: The scan stops at the first invalid mask entry i and reports `hit`=0 with `cycles`=i+1. An empty mask table therefore gives `cycles`=1.
- R6: `done` is high for exactly one clock per scan. If `start` is sampled at edge E, `done` is high in the clock that follows edge E+`cycles`.
- R7: `hit` and `cycles` change only together with `done`, and they hold their values until the next scan completes.
- R8: A configuration write that arrives while a scan is in progress has no effect on either table. A write made while idle takes effect for the next scan.
- R9: A `start` pulse that arrives while a scan is in progress is ignored, and the running scan completes with the address it captured.
- R10: A write with `cfgSel`=0 targets the mask table and a write with `cfgSel`=1 targets the network-identifier table. `cfgIdx` selects the entry, `cfgData` is stored, and `cfgValid` sets the entry's valid bit (1) or clears it (0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 1 | Table select: 0 = mask table, 1 = network-identifier table |
| cfgIdx | input | 4 | Entry index for the write |
| cfgData | input | 32 | Mask or network identifier to store |
| cfgValid | input | 1 | Valid bit written with the entry |
| start | input | 1 | Begin a scan of `addrIn` |
| addrIn | input | 32 | Address to classify |
| done | output | 1 | One-cycle completion pulse |
| hit | output | 1 | 1 = address lies in a configured range |
| cycles | output | 5 | Number of scan cycles used by the last scan |

## Verification
The assertions assume that `start` is a single-cycle pulse, and that the block gives no result unless a scan was actually started. They also assume that no output activity is expected in the reset cycles. The stimulus drives `start` for one clock only. It issues configuration writes and repeated starts at chosen points, both inside and outside a running scan, so the lock-out rules are exercised deliberately rather than by accident. Addresses and table contents are chosen so that the hit lands on the first entry, on a middle entry and on the last entry, and also so that the scan stops at an invalid entry or runs through all 16 entries without a match.

// File: rtl/range_match_pkg.sv
package range_match_pkg;

  // Strobes from the sequencer to the datapath.
  typedef struct packed {
    logic cfgAllow;   // table writes permitted this cycle
    logic load;       // capture address, rewind index
    logic advance;    // step to next mask entry
    logic finish;     // register the verdict
  } scanCtrl_t;

  // Observations from the datapath back to the sequencer.
  typedef struct packed {
    logic entryValid; // current mask entry is populated
    logic netHit;     // masked address found in id table
    logic atLast;     // current index is the final entry
  } scanStat_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SCAN = 1'b1
  } scanState_e;

endpackage

// File: rtl/rms_datapath.sv
module rms_datapath
  import range_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  scanCtrl_t         ctrl,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgValid,
  input  logic [ADDR_W-1:0] addrIn,
  output scanStat_t         stat,
  output logic              hit,
  output logic [CNT_W-1:0]  cycles
);

  logic [ADDR_W-1:0] maskMem [DEPTH];
  logic [ADDR_W-1:0] netMem  [DEPTH];
  logic [DEPTH-1:0]  maskVld;
  logic [DEPTH-1:0]  netVld;

  logic [ADDR_W-1:0] addrReg;
  logic [IDX_W-1:0]  idxReg;
  logic [ADDR_W-1:0] curMask;
  logic [ADDR_W-1:0] maskedAddr;
  logic [DEPTH-1:0]  netMatch;

  logic maskWr;
  logic netWr;

  assign maskWr = ctrl.cfgAllow && cfgWrEn && !cfgSel;
  assign netWr  = ctrl.cfgAllow && cfgWrEn &&  cfgSel;

  // Table storage, one generate slice per entry.
  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rstN) begin
        maskMem[e] <= '0;
        maskVld[e] <= 1'b0;
      end else if (maskWr && cfgIdx == IDX_W'(e)) begin
        maskMem[e] <= cfgData;
        maskVld[e] <= cfgValid;
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        netMem[e] <= '0;
        netVld[e] <= 1'b0;
      end else if (netWr && cfgIdx == IDX_W'(e)) begin
        netMem[e] <= cfgData;
        netVld[e] <= cfgValid;
      end
    end

    // Exact-match lookup of the masked address, all ids in parallel.
    assign netMatch[e] = netVld[e] && (netMem[e] == maskedAddr);
  end

  // Scan registers.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      idxReg  <= '0;
    end else if (ctrl.load) begin
      addrReg <= addrIn;
      idxReg  <= '0;
    end else if (ctrl.advance) begin
      idxReg  <= idxReg + 1'b1;
    end
  end

  assign curMask    = maskMem[idxReg];
  assign maskedAddr = addrReg & curMask;

  assign stat.entryValid = maskVld[idxReg];
  assign stat.netHit     = |netMatch;
  assign stat.atLast     = (idxReg == IDX_W'(DEPTH - 1));

  // Verdict registers, updated only when a scan completes.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      hit    <= 1'b0;
      cycles <= '0;
    end else if (ctrl.finish) begin
      hit    <= stat.entryValid && stat.netHit;
      cycles <= {1'b0, idxReg} + 1'b1;
    end
  end

endmodule

// File: rtl/rms_control.sv
module rms_control
  import range_match_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  scanStat_t stat,
  output scanCtrl_t ctrl,
  output logic      scanActive,
  output logic      done
);

  scanState_e state;
  logic       scanEnds;

  assign scanEnds = !stat.entryValid || stat.netHit || stat.atLast;

  always_comb begin
    ctrl = '0;
    unique case (state)
      ST_IDLE: begin
        ctrl.cfgAllow = 1'b1;
        ctrl.load     = start;
      end
      ST_SCAN: begin
        ctrl.finish  = scanEnds;
        ctrl.advance = !scanEnds;
      end
      default: ctrl = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      done <= ctrl.finish;
      unique case (state)
        ST_IDLE: if (start)       state <= ST_SCAN;
        ST_SCAN: if (ctrl.finish) state <= ST_IDLE;
        default:                  state <= ST_IDLE;
      endcase
    end
  end

  assign scanActive = (state == ST_SCAN);

endmodule

// File: rtl/range_match_scanner.sv
module range_match_scanner
  import range_match_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DEPTH  = 16,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [IDX_W-1:0]  cfgIdx,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              cfgValid,
  input  logic              start,
  input  logic [ADDR_W-1:0] addrIn,
  output logic              done,
  output logic              hit,
  output logic [CNT_W-1:0]  cycles
);

  scanCtrl_t ctrl;
  scanStat_t stat;
  logic      scanActive;

  rms_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .start      (start),
    .stat       (stat),
    .ctrl       (ctrl),
    .scanActive (scanActive),
    .done       (done)
  );

  rms_datapath #(
    .ADDR_W (ADDR_W),
    .DEPTH  (DEPTH)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .cfgIdx   (cfgIdx),
    .cfgData  (cfgData),
    .cfgValid (cfgValid),
    .addrIn   (addrIn),
    .stat     (stat),
    .hit      (hit),
    .cycles   (cycles)
  );

endmodule

// File: rtl/rms_checker.sv
module rms_checker #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             scanActive,
  input logic             done,
  input logic             hit,
  input logic [CNT_W-1:0] cycles
);

  // R6: completion is a single-cycle pulse
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: a completion always closes a scan that was running
  assert_done_after_scan_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(scanActive));

  // R7: verdict outputs hold between completions
  assert_verdict_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    !done |-> ($stable(hit) && $stable(cycles)));

  // R4: reported cycle count stays within the table depth
  assert_cycles_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (cycles >= CNT_W'(1) && cycles <= CNT_W'(DEPTH)));

  // R2: a scan only begins in response to start
  assert_scan_needs_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(scanActive) |-> $past(start));

endmodule

bind range_match_scanner rms_checker #(
  .DEPTH (DEPTH),
  .CNT_W (CNT_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .start      (start),
  .scanActive (scanActive),
  .done       (done),
  .hit        (hit),
  .cycles     (cycles)
);

// File: tb/range_match_scanner_tb.sv
module range_match_scanner_tb;

  logic        clk = 1'b0;
  logic        rstN;
  logic        cfgWrEn;
  logic        cfgSel;
  logic [3:0]  cfgIdx;
  logic [31:0] cfgData;
  logic        cfgValid;
  logic        start;
  logic [31:0] addrIn;
  logic        done;
  logic        hit;
  logic [4:0]  cycles;

  int checks = 0;
  int errors = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;  // 125 MHz

  range_match_scanner u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgIdx(cfgIdx), .cfgData(cfgData), .cfgValid(cfgValid),
    .start(start), .addrIn(addrIn), .done(done), .hit(hit), .cycles(cycles)
  );

  // Behavioural reference model
  logic [31:0] mMask [16];
  logic [31:0] mNet  [16];
  bit          mMaskV [16];
  bit          mNetV  [16];
  bit          mBusy;
  int          mIdx;
  logic [31:0] mAddr;
  bit          expDone;
  bit          expHit;
  int          expCyc;

  always @(posedge clk) begin
    cycleCount++;
    if (!rstN) begin
      for (int i = 0; i < 16; i++) begin
        mMaskV[i] = 0; mNetV[i] = 0; mMask[i] = '0; mNet[i] = '0;
      end
      mBusy = 0; mIdx = 0; mAddr = '0;
      expDone = 0; expHit = 0; expCyc = 0;
    end else begin
      expDone = 0;
      if (!mBusy) begin
        if (cfgWrEn) begin
          if (!cfgSel) begin mMask[cfgIdx] = cfgData; mMaskV[cfgIdx] = cfgValid; end
          else         begin mNet[cfgIdx]  = cfgData; mNetV[cfgIdx]  = cfgValid; end
        end
        if (start) begin mBusy = 1; mIdx = 0; mAddr = addrIn; end
      end else begin
        bit found;
        found = 0;
        if (mMaskV[mIdx])
          for (int j = 0; j < 16; j++)
            if (mNetV[j] && mNet[j] == (mAddr & mMask[mIdx])) found = 1;
        if (!mMaskV[mIdx] || found || mIdx == 15) begin
          expDone = 1; expHit = found; expCyc = mIdx + 1; mBusy = 0;
        end else begin
          mIdx++;
        end
      end
    end
  end

  // Per-clock comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      checks++;
      if (done !== expDone) begin
        errors++;
        $display("FAIL R6 done actual=%0b expected=%0b", done, expDone);
      end
      checks++;
      if (hit !== expHit || cycles !== 5'(expCyc)) begin
        errors++;
        $display("FAIL R7 hit/cycles actual=%0b/%0d expected=%0b/%0d",
                 hit, cycles, expHit, expCyc);
      end
    end
  end

  task automatic cfgWrite(input bit sel, input int idx, input logic [31:0] data, input bit vld);
    @(negedge clk);
    cfgWrEn = 1; cfgSel = sel; cfgIdx = 4'(idx); cfgData = data; cfgValid = vld;
    @(negedge clk);
    cfgWrEn = 0;
  endtask

  task automatic runScan(input logic [31:0] addr, input bit eHit, input int eCyc,
                         input string tag,
                         input bit midWr = 0, input bit midSel = 0, input int midIdx = 0,
                         input logic [31:0] midData = '0,
                         input bit midStart = 0, input logic [31:0] midAddr = '0);
    int k;
    @(negedge clk);
    start = 1; addrIn = addr;
    k = 0;
    @(negedge clk);
    k++;
    start = 0;
    if (midWr) begin
      cfgWrEn = 1; cfgSel = midSel; cfgIdx = 4'(midIdx); cfgData = midData; cfgValid = 1;
    end
    if (midStart) begin start = 1; addrIn = midAddr; end
    if (!done) begin
      @(negedge clk);
      k++;
      cfgWrEn = 0; start = 0;
      while (!done && k < 64) begin
        @(negedge clk);
        k++;
      end
    end
    cfgWrEn = 0; start = 0;
    checks++;
    if (!done) begin
      errors++;
      $display("FAIL %s no done actual=0 expected=1", tag);
    end
    checks++;
    if (hit !== eHit || cycles !== 5'(eCyc)) begin
      errors++;
      $display("FAIL %s result actual hit=%0b cycles=%0d expected hit=%0b cycles=%0d",
               tag, hit, cycles, eHit, eCyc);
    end
    checks++;
    if (k != eCyc + 1) begin   // R6 latency: done follows edge start+cycles
      errors++;
      $display("FAIL R6 latency actual=%0d expected=%0d", k, eCyc + 1);
    end
  endtask

  initial begin
    wait (cycleCount >= 20000);
    errors++;
    $display("FAIL watchdog actual=%0d cycles expected=<20000", cycleCount);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 0; cfgWrEn = 0; cfgSel = 0; cfgIdx = '0; cfgData = '0; cfgValid = 0;
    start = 0; addrIn = '0;
    repeat (4) @(negedge clk);
    checks++;
    if (done !== 0 || hit !== 0 || cycles !== 0) begin
      errors++;
      $display("FAIL R1 reset outputs actual=%0b/%0b/%0d expected=0/0/0", done, hit, cycles);
    end
    rstN = 1;

    // R1, R5: empty table reports no-match after one cycle
    runScan(32'h0A01_0507, 0, 1, "R5 empty");

    // R10: load masks and ids
    cfgWrite(0, 0, 32'hFFFF_0000, 1);
    cfgWrite(0, 1, 32'hFFFF_FF00, 1);
    cfgWrite(1, 0, 32'h0A01_0000, 1);
    cfgWrite(1, 1, 32'hC0A8_0100, 1);

    runScan(32'h0A01_0507, 1, 1, "R3 first entry");
    runScan(32'hC0A8_0109, 1, 2, "R3 second entry");
    runScan(32'h0808_0808, 0, 3, "R5 stop at invalid");

    for (int i = 2; i < 15; i++) cfgWrite(0, i, 32'hFFFF_FFFF, 1);
    cfgWrite(0, 15, 32'hFF00_0000, 1);
    cfgWrite(1, 2, 32'h0800_0000, 1);

    runScan(32'h0808_0808, 1, 16, "R3 last entry");
    runScan(32'h0909_0909, 0, 16, "R4 full no-match");

    // R8: write during scan is ignored
    runScan(32'h0909_0909, 0, 16, "R8 mid write", 1, 1, 3, 32'h0900_0000);
    runScan(32'h0909_0909, 0, 16, "R8 after ignored write");
    cfgWrite(1, 3, 32'h0900_0000, 1);
    runScan(32'h0909_0909, 1, 16, "R8 idle write accepted");

    // R9: start during scan is ignored
    runScan(32'hC0A8_0109, 1, 2, "R9 mid start", 0, 0, 0, '0, 1, 32'h0A01_0507);

    // R10: clearing valid bits
    cfgWrite(0, 1, 32'hFFFF_FF00, 0);
    runScan(32'hC0A8_0109, 0, 2, "R10 mask cleared");
    cfgWrite(1, 0, 32'h0A01_0000, 0);
    runScan(32'h0A01_0507, 0, 2, "R10 id cleared");

    // R7: outputs hold while idle
    repeat (5) @(negedge clk);
    checks++;
    if (hit !== 0 || cycles !== 5'd2) begin
      errors++;
      $display("FAIL R7 hold actual=%0b/%0d expected=0/2", hit, cycles);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule